// File: doc/BRIEF.md
# Burst Bus Target Interface

This block is a synchronous target on a shared bus where address and data use the same 32 lines. A transaction opens with an address phase, which is the first clock with the active-low frame input low. In that clock the 32-bit bus carries the start address and the 4-bit lane carries a command. In each later clock the same 4-bit lane carries active-low byte enables for the data word on the bus.

The target claims the transaction only when two things hold: the address lies inside its window of `WORDS` 32-bit words, which starts at `BASE_ADDR`, and the command is a memory read or a memory write. Once it has claimed a transaction, it acknowledges selection after a fixed delay. It then moves one word per clock in which both ready signals are low, reading from or writing to a small internal register array at addresses that increase by one word each time. It can add wait states before each word. When a burst would run past the last word of its window, it asks the initiator to stop.

The bus pins are modelled as separate in and out ports plus an output enable. Arbitration, configuration cycles and parity are handled elsewhere.

Top module: `burst_target`

## Requirements
- R1: A claimed transaction drives `devselN` low in clock SEL_DLY+1 after the address phase, which is never later than the third clock. A transaction is claimed when `adIn[31:6]` matches the base and the lane holds 4'b0110 (memory read) or 4'b0111 (memory write).
- R2: For an address outside the window, or for any other command, `devselN`, `trdyN` and `stopN` stay high and `adOe` stays low. The array is not changed, and the target waits until `frameN` and `irdyN` are both high before it watches for a new address phase.
- R3: On a write, byte lane b (bits 8b+7..8b) of the addressed word takes the value on `adIn` only when `cmdBeN[b]` is 0. The other bytes keep their old values.
- R4: During the data phases of a read, `adOe` is high and `adOut` shows the addressed word. During a write, or when the target is not selected, `adOe` is low.
- R5: A word moves only at a clock edge where `irdyN` and `trdyN` are both low. While `irdyN` is high, the word address does not change and the read data stays the same.
- R6: `trdyN` first goes low WAIT_CYC clocks after `devselN` goes low. After every word that moves with the burst still open, `trdyN` stays high for WAIT_CYC clocks.
- R7: The first word moved uses the address from the address phase, and each later word uses the next word address. The burst keeps going for as long as the initiator holds `frameN` low.
- R8: When a word moves while `frameN` is high, that word is the last one. In the next clock `devselN`, `trdyN` and `stopN` are all high.
- R9: When the word at the top index of the window moves while `frameN` is still low, the target holds `stopN` low with `devselN` low and `trdyN` high until it sees `frameN` high. No further word moves, and after that the target is idle.
- R10: During reset, `devselN`, `trdyN` and `stopN` are high, `adOe` is low, and every word of the array is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameN | input | 1 | Transaction frame from the initiator, active low |
| adIn | input | 32 | Address in the address phase, write data in the data phases |
| cmdBeN | input | 4 | Command in the address phase, active-low byte enables in the data phases |
| irdyN | input | 1 | Initiator ready, active low |
| adOut | output | 32 | Read data for the shared bus |
| adOe | output | 1 | Output enable for `adOut` |
| devselN | output | 1 | Selection acknowledge, active low |
| trdyN | output | 1 | Target ready, active low |
| stopN | output | 1 | Request to end the transaction, active low |

## Verification
The assertions assume the initiator follows the protocol. It raises `frameN` only in the clock that carries its final word, it keeps `irdyN` low once `frameN` is high, and it leaves one clock with both signals high before the next address phase. The latency check also assumes that `frameN` does not fall except at an address phase. The bench's initiator task builds every transaction to match these rules, including random pauses, random byte enables, random start indices and lengths, and unclaimed cycles that end on their own. It therefore never drives a cycle that the assertions treat as illegal.

// File: rtl/burst_target_pkg.sv
package burst_target_pkg;

  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;

  localparam logic [LANES-1:0] CMD_MEM_RD = 4'b0110;
  localparam logic [LANES-1:0] CMD_MEM_WR = 4'b0111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELWAIT,
    ST_DATA,
    ST_STOP,
    ST_IGNORE
  } tgtState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic advance;
    logic writeWord;
  } dpStrobe_t;

endpackage

// File: rtl/burst_target_ctrl.sv
module burst_target_ctrl
  import burst_target_pkg::*;
#(
  parameter int SEL_DLY  = 1,   // 0..2, select acknowledge in clock SEL_DLY+1
  parameter int WAIT_CYC = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic [LANES-1:0] cmdLane,
  input  logic             addrHit,
  input  logic             atLast,
  output dpStrobe_t        strobe,
  output logic             devselN,
  output logic             trdyN,
  output logic             stopN,
  output logic             adOe
);

  localparam logic [1:0] SEL_INIT = (SEL_DLY > 0) ? 2'(SEL_DLY - 1) : 2'd0;
  localparam int WAIT_W = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;
  localparam logic [WAIT_W-1:0] WAIT_INIT = WAIT_W'(WAIT_CYC);

  tgtState_t         state, stateNxt;
  logic [1:0]        selCnt, selCntNxt;
  logic [WAIT_W-1:0] waitCnt, waitCntNxt;
  logic              isWrite, isWriteNxt;
  logic              cmdOk;
  logic              ready;
  logic              xfer;

  assign cmdOk = (cmdLane == CMD_MEM_RD) || (cmdLane == CMD_MEM_WR);
  assign ready = (state == ST_DATA) && (waitCnt == '0);
  assign xfer  = ready && !irdyN;

  always_comb begin
    stateNxt   = state;
    selCntNxt  = selCnt;
    waitCntNxt = waitCnt;
    isWriteNxt = isWrite;
    strobe     = '0;
    case (state)
      ST_IDLE: begin
        if (!frameN) begin
          if (addrHit && cmdOk) begin
            strobe.loadAddr = 1'b1;
            isWriteNxt      = (cmdLane == CMD_MEM_WR);
            if (SEL_DLY == 0) begin
              stateNxt   = ST_DATA;
              waitCntNxt = WAIT_INIT;
            end else begin
              stateNxt  = ST_SELWAIT;
              selCntNxt = SEL_INIT;
            end
          end else begin
            stateNxt = ST_IGNORE;
          end
        end
      end
      ST_SELWAIT: begin
        if (selCnt == 2'd0) begin
          stateNxt   = ST_DATA;
          waitCntNxt = WAIT_INIT;
        end else begin
          selCntNxt = selCnt - 2'd1;
        end
      end
      ST_DATA: begin
        if (xfer) begin
          strobe.advance   = 1'b1;
          strobe.writeWord = isWrite;
          if (frameN)      stateNxt = ST_IDLE;
          else if (atLast) stateNxt = ST_STOP;
          else             waitCntNxt = WAIT_INIT;
        end else if (waitCnt != '0) begin
          waitCntNxt = waitCnt - WAIT_W'(1);
        end
      end
      ST_STOP: begin
        if (frameN) stateNxt = ST_IDLE;
      end
      ST_IGNORE: begin
        if (frameN && irdyN) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      selCnt  <= 2'd0;
      waitCnt <= '0;
      isWrite <= 1'b0;
    end else begin
      state   <= stateNxt;
      selCnt  <= selCntNxt;
      waitCnt <= waitCntNxt;
      isWrite <= isWriteNxt;
    end
  end

  assign devselN = !((state == ST_DATA) || (state == ST_STOP));
  assign trdyN   = !ready;
  assign stopN   = (state != ST_STOP);
  assign adOe    = (state == ST_DATA) && !isWrite;

endmodule

// File: rtl/burst_target_dp.sv
module burst_target_dp
  import burst_target_pkg::*;
#(
  parameter int          WORDS     = 16,
  parameter logic [31:0] BASE_ADDR = 32'h0000_4000
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [BUS_W-1:0] adIn,
  input  logic [LANES-1:0] cmdBeN,
  output logic             addrHit,
  output logic             atLast,
  output logic [BUS_W-1:0] rdWord
);

  localparam int IDX_W    = $clog2(WORDS);
  localparam int ADDR_LSB = IDX_W + 2;

  logic [IDX_W-1:0] idx;
  logic [BUS_W-1:0] mem [WORDS];
  logic [BUS_W-1:0] merged;
  logic [1:0]       unusedLowBits;

  assign unusedLowBits = adIn[1:0];
  assign addrHit = (adIn[BUS_W-1:ADDR_LSB] == BASE_ADDR[BUS_W-1:ADDR_LSB]);
  assign atLast  = (idx == IDX_W'(WORDS - 1));
  assign rdWord  = mem[idx];

  // byte-lane merge of write data into the addressed word
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign merged[b*8 +: 8] = cmdBeN[b] ? rdWord[b*8 +: 8] : adIn[b*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
    end else if (strobe.loadAddr) begin
      idx <= adIn[ADDR_LSB-1:2];
    end else if (strobe.advance) begin
      idx <= idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else if (strobe.writeWord) begin
      mem[idx] <= merged;
    end
  end

endmodule

// File: rtl/burst_target.sv
module burst_target
  import burst_target_pkg::*;
#(
  parameter int          WORDS     = 16,
  parameter logic [31:0] BASE_ADDR = 32'h0000_4000,
  parameter int          SEL_DLY   = 1,
  parameter int          WAIT_CYC  = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic [31:0] adIn,
  input  logic [3:0]  cmdBeN,
  input  logic        irdyN,
  output logic [31:0] adOut,
  output logic        adOe,
  output logic        devselN,
  output logic        trdyN,
  output logic        stopN
);

  dpStrobe_t strobe;
  logic      addrHit;
  logic      atLast;

  burst_target_ctrl #(
    .SEL_DLY (SEL_DLY),
    .WAIT_CYC(WAIT_CYC)
  ) ctrlInst (
    .clk    (clk),
    .rstN   (rstN),
    .frameN (frameN),
    .irdyN  (irdyN),
    .cmdLane(cmdBeN),
    .addrHit(addrHit),
    .atLast (atLast),
    .strobe (strobe),
    .devselN(devselN),
    .trdyN  (trdyN),
    .stopN  (stopN),
    .adOe   (adOe)
  );

  burst_target_dp #(
    .WORDS    (WORDS),
    .BASE_ADDR(BASE_ADDR)
  ) dpInst (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .adIn   (adIn),
    .cmdBeN (cmdBeN),
    .addrHit(addrHit),
    .atLast (atLast),
    .rdWord (adOut)
  );

endmodule

// File: rtl/burst_target_chk.sv
module burst_target_chk (
  input logic clk,
  input logic rstN,
  input logic frameN,
  input logic irdyN,
  input logic devselN,
  input logic trdyN,
  input logic stopN,
  input logic adOe
);

  logic       prevFrameN;
  logic [2:0] sinceAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevFrameN <= 1'b1;
      sinceAddr  <= 3'd0;
    end else begin
      prevFrameN <= frameN;
      if (prevFrameN && !frameN)                 sinceAddr <= 3'd1;
      else if (sinceAddr != 3'd0 && sinceAddr != 3'd7) sinceAddr <= sinceAddr + 3'd1;
    end
  end

  // R1
  sel_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devselN) |-> (sinceAddr >= 3'd1 && sinceAddr <= 3'd3));

  // R4
  oe_needs_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> !devselN);

  // R5
  ready_needs_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN |-> (!devselN && stopN));

  // R8
  last_word_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!devselN && !trdyN && !irdyN && frameN) |=> (devselN && trdyN && stopN));

  // R9
  stop_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stopN |-> (!devselN && trdyN && !adOe));

  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stopN && !frameN) |=> !stopN);

endmodule

bind burst_target burst_target_chk chkInst (
  .clk    (clk),
  .rstN   (rstN),
  .frameN (frameN),
  .irdyN  (irdyN),
  .devselN(devselN),
  .trdyN  (trdyN),
  .stopN  (stopN),
  .adOe   (adOe)
);

// File: tb/tb_burst_target.sv
module tb_burst_target;

  localparam int          CLK_PERIOD = 10;
  localparam int          WORDS      = 16;
  localparam logic [31:0] BASE       = 32'h0000_4000;
  localparam int          SEL_DLY    = 1;
  localparam int          WAIT_CYC   = 1;
  localparam logic [3:0]  CMD_RD     = 4'b0110;
  localparam logic [3:0]  CMD_WR     = 4'b0111;

  logic        clk = 1'b0;
  logic        rstN;
  logic        frameN;
  logic [31:0] adIn;
  logic [3:0]  cmdBeN;
  logic        irdyN;
  logic [31:0] adOut;
  logic        adOe;
  logic        devselN;
  logic        trdyN;
  logic        stopN;

  int nChecks = 0;
  int nFail   = 0;
  logic [31:0] model [WORDS];

  always #(CLK_PERIOD / 2) clk = ~clk;

  burst_target #(
    .WORDS(WORDS), .BASE_ADDR(BASE), .SEL_DLY(SEL_DLY), .WAIT_CYC(WAIT_CYC)
  ) dut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .adIn(adIn), .cmdBeN(cmdBeN),
    .irdyN(irdyN), .adOut(adOut), .adOe(adOe), .devselN(devselN),
    .trdyN(trdyN), .stopN(stopN)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mergeBytes(input logic [31:0] old,
      input logic [31:0] nw, input logic [3:0] beN);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (!beN[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  function automatic bit inWindow(input logic [31:0] a);
    return a[31:6] == BASE[31:6];
  endfunction

  task automatic runTxn(input logic [31:0] addr, input logic [3:0] cmd,
      input int n, input bit pauses, input bit randBe, input logic [3:0] fixedBe);
    bit hit, isWr, done, lastW, stopSeen, prevXfer, prevPause;
    int cyc, cnt, expWords, devLat, trdyLat, idx;
    logic [31:0] wData;
    logic [3:0]  wBe;
    hit = inWindow(addr) && (cmd == CMD_RD || cmd == CMD_WR);
    isWr = (cmd == CMD_WR);
    idx = int'((addr >> 2) % WORDS);
    expWords = hit ? ((n < WORDS - idx) ? n : WORDS - idx) : 0;
    done = 0; stopSeen = 0; prevXfer = 0; prevPause = 0;
    cyc = 0; cnt = 0; devLat = -1; trdyLat = -1;
    wData = $urandom;
    wBe = randBe ? 4'($urandom) : fixedBe;
    @(negedge clk);
    frameN = 1'b0; adIn = addr; cmdBeN = cmd; irdyN = 1'b1;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (!devselN && devLat < 0) devLat = cyc;
      if (!trdyN && trdyLat < 0) trdyLat = cyc;
      if (prevXfer && WAIT_CYC > 0) check(trdyN == 1'b1, "R6 wait after word", trdyN, 1);
      prevXfer = 0;
      if (!hit) begin
        check({devselN, trdyN, stopN, adOe} == 4'b1110, "R2 unclaimed outputs",
              {devselN, trdyN, stopN, adOe}, 4'b1110);
        adIn = wData; cmdBeN = wBe; irdyN = 1'b0;
        if (cyc >= 5) begin frameN = 1'b1; irdyN = 1'b1; done = 1; end
        continue;
      end
      if (cyc > 80) begin
        check(0, "R7 burst progress", cnt, expWords);
        frameN = 1'b1; irdyN = 1'b1; done = 1;
        continue;
      end
      if (!stopN) begin
        stopSeen = 1;
        check(trdyN && !devselN, "R9 stop shape", {devselN, trdyN}, 2'b01);
        frameN = 1'b1; irdyN = 1'b1;
        @(negedge clk);
        check(devselN && stopN && trdyN, "R9 release after stop",
              {devselN, trdyN, stopN}, 3'b111);
        done = 1;
        continue;
      end
      check(adOe == (!isWr && !devselN), "R4 output enable", adOe, !isWr && !devselN);
      if (!isWr && !trdyN)
        check(adOut == model[idx], prevPause ? "R5 read held over pause" : "R4 read data",
              adOut, model[idx]);
      lastW = (cnt == n - 1);
      adIn = isWr ? wData : $urandom;
      cmdBeN = isWr ? wBe : 4'b0000;
      if (lastW) begin
        frameN = 1'b1; irdyN = 1'b0;
      end else begin
        irdyN = (pauses && ($urandom % 3 == 0)) ? 1'b1 : 1'b0;
      end
      prevPause = irdyN && !trdyN;
      if (!irdyN && !trdyN) begin
        if (isWr) model[idx] = mergeBytes(model[idx], wData, wBe);
        cnt++;
        idx = (idx + 1) % WORDS;
        wData = $urandom;
        wBe = randBe ? 4'($urandom) : fixedBe;
        prevXfer = 1;
        if (lastW) begin
          @(negedge clk);
          check(devselN && trdyN && stopN, "R8 release after last word",
                {devselN, trdyN, stopN}, 3'b111);
          irdyN = 1'b1;
          done = 1;
        end
      end
    end
    frameN = 1'b1; irdyN = 1'b1;
    if (hit) begin
      check(devLat == SEL_DLY + 1, "R1 select latency", devLat, SEL_DLY + 1);
      check(trdyLat == SEL_DLY + 1 + WAIT_CYC, "R6 first ready", trdyLat,
            SEL_DLY + 1 + WAIT_CYC);
      check(cnt == expWords, "R7 words moved", cnt, expWords);
      check(stopSeen == (n > expWords), "R9 stop at window end", stopSeen, n > expWords);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int w = 0; w < WORDS; w++) model[w] = '0;
    rstN = 1'b0; frameN = 1'b1; irdyN = 1'b1; adIn = '0; cmdBeN = 4'hF;
    repeat (3) @(negedge clk);
    // R10: outputs idle during reset
    check({devselN, trdyN, stopN, adOe} == 4'b1110, "R10 reset outputs",
          {devselN, trdyN, stopN, adOe}, 4'b1110);
    rstN = 1'b1;
    @(negedge clk);
    // R10: array cleared (reads of zero)
    runTxn(BASE + 32'd20, CMD_RD, 4, 0, 0, 4'h0);
    // R3: single full write then partial write
    runTxn(BASE + 32'd12, CMD_WR, 1, 0, 0, 4'h0);
    runTxn(BASE + 32'd12, CMD_WR, 1, 0, 0, 4'b1010);
    runTxn(BASE + 32'd12, CMD_RD, 1, 0, 0, 4'h0);
    // R9: write burst running off the window top
    runTxn(BASE + 32'd48, CMD_WR, 8, 0, 0, 4'h0);
    // R5: read with initiator pauses
    runTxn(BASE + 32'd40, CMD_RD, 6, 1, 0, 4'h0);
    // R2: out of window and unsupported command
    runTxn(BASE + 32'd64, CMD_WR, 3, 0, 0, 4'h0);
    runTxn(BASE + 32'd4, 4'b0011, 3, 0, 0, 4'h0);
    runTxn(BASE - 32'd4, CMD_RD, 2, 0, 0, 4'h0);
    // R7 R9: read starting on the top word
    runTxn(BASE + 32'd60, CMD_RD, 3, 1, 0, 4'h0);
    for (int t = 0; t < 60; t++) begin
      logic [31:0] a;
      logic [3:0]  c;
      int sel = int'($urandom % 10);
      a = BASE + {26'd0, 4'($urandom), 2'b00};
      c = ($urandom % 2) ? CMD_WR : CMD_RD;
      if (sel == 0) a = BASE + 32'h100 + {26'd0, 4'($urandom), 2'b00};
      if (sel == 1) c = 4'b0010;
      runTxn(a, c, 1 + int'($urandom % 9), 1, 1, 4'h0);
    end
    // R7: full window readback in one burst
    runTxn(BASE, CMD_RD, WORDS, 1, 0, 4'h0);
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule